// File: doc/BRIEF.md
# Single-Slave Bus Reset and Address Select Sequencer

This block prepares one slave on a single-wire open-drain bus for a later transfer. When started it commands a bus reset through the bit timing engine and checks whether a device answered with a presence pulse. If nothing answered, it ends with an error and sends no bytes. Otherwise it addresses the slave.

The slave count decides how the slave is addressed. With exactly one known slave, a single broadcast "skip address" command byte is sent. With any other count, a "match address" command byte is sent, followed by the eight bytes of the target's 64-bit identifier. Each byte is handed to the bit timing engine as one write-byte command. The next command is issued only after the engine reports that the previous one has finished.

The target identifier and the slave count are captured when the start is accepted. Later changes on those inputs have no effect on a selection that is already running. A start that arrives while a selection is running is ignored.

Top module: `onew_sel_seq`

## Requirements
- R1: In the cycle after an accepted `start_i`, `cmd_valid_o` is 1 with `cmd_kind_o` = 0 (bus reset). No command of any kind comes before it.
- R2: If the reset completes with `eng_presence_i` = 0, the block pulses `done_o` with `err_o` = 1 and issues no write-byte command.
- R3: If the captured slave count equals 1, exactly one write-byte command (`cmd_kind_o` = 1) is issued after the reset, carrying 0xCC.
- R4: For any other slave count (including 0), nine write-byte commands are issued. The first carries 0x55, and the next eight carry the target ID bytes: bits [7:0] first (family code), then [15:8], and so on up to [63:56].
- R5: `cmd_valid_o` is high for exactly one cycle per command. No new command is issued until `eng_done_i` has been seen for the previous one.
- R6: `done_o` is a one-cycle pulse in the cycle after the `eng_done_i` that completes the selection (the last byte, or a reset with no presence).
- R7: `err_o` keeps its value from one `done_o` until the next accepted start, and is cleared in the cycle after that start.
- R8: `start_i` asserted while a selection is in progress is ignored. The running sequence and its commands are unchanged.
- R9: Changes on `target_id_i` or `slave_count_i` after the start is accepted do not alter the bytes sent.
- R10: After reset, `cmd_valid_o`, `done_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a selection (accepted when idle) |
| slave_count_i | input | SLV_W | Number of known slaves on the bus |
| target_id_i | input | 64 | 64-bit identifier of the slave to address |
| cmd_valid_o | output | 1 | One-cycle command strobe to the bit timing engine |
| cmd_kind_o | output | 1 | 0 = bus reset, 1 = write byte |
| cmd_byte_o | output | 8 | Byte to write (valid when `cmd_kind_o` = 1) |
| eng_done_i | input | 1 | Engine finished the current command |
| eng_presence_i | input | 1 | Presence seen during the reset, valid with `eng_done_i` |
| done_o | output | 1 | One-cycle pulse when the selection ends |
| err_o | output | 1 | 1 if the last selection found no presence |

## Verification
The hardest situation to reach from the ports is a start pulse, together with a changed identifier and slave count, arriving while a match sequence is midway through its byte train. The bench reaches it with an engine model whose completion latency is set per run. This keeps the sequencer waiting on a byte while the driver inverts `target_id_i`, switches `slave_count_i` to the skip value and pulses `start_i`. The scoreboard queue still expects the original nine bytes. Back-to-back runs with latency 1 also check that every completion is followed by the next command with no gap and no duplicate.

// File: rtl/onew_sel_pkg.sv
package onew_sel_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RST_GO,
    S_RST_WAIT,
    S_BYTE_GO,
    S_BYTE_WAIT
  } sel_state_e;

  localparam logic CMD_RESET = 1'b0;
  localparam logic CMD_WRITE = 1'b1;
endpackage

// File: rtl/onew_byte_sched.sv
module onew_byte_sched #(
  parameter int ID_BYTES   = 8,
  parameter logic [7:0] SKIP_CODE  = 8'hCC,
  parameter logic [7:0] MATCH_CODE = 8'h55,
  localparam int IDX_W = $clog2(ID_BYTES + 1)
) (
  input  logic [ID_BYTES*8-1:0] id_i,
  input  logic                  skip_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [7:0]            byte_o,
  output logic [IDX_W-1:0]      last_idx_o
);
  logic [7:0] id_bytes [ID_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_split
    assign id_bytes[g] = id_i[g*8 +: 8];
  end

  // slot 0 is the command, slots 1..ID_BYTES carry the ID lowest byte first
  always_comb begin
    byte_o = skip_i ? SKIP_CODE : MATCH_CODE;
    for (int k = 0; k < ID_BYTES; k++) begin
      if (idx_i == IDX_W'(k + 1)) byte_o = id_bytes[k];
    end
  end

  assign last_idx_o = skip_i ? '0 : IDX_W'(ID_BYTES);
endmodule

// File: rtl/onew_sel_fsm.sv
module onew_sel_fsm
  import onew_sel_pkg::*;
#(
  parameter int ID_BYTES = 8,
  localparam int IDX_W = $clog2(ID_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             eng_done_i,
  input  logic             eng_presence_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             load_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             cmd_valid_o,
  output logic             cmd_kind_o,
  output logic             done_o,
  output logic             err_o
);
  sel_state_e       st_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o = start_i && (st_q == S_IDLE);
  assign busy_o = (st_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q  <= S_RST_GO;
          idx_q <= '0;
          err_o <= 1'b0;
        end
        S_RST_GO: st_q <= S_RST_WAIT;
        S_RST_WAIT: if (eng_done_i) begin
          if (!eng_presence_i) begin
            err_o  <= 1'b1;
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            st_q <= S_BYTE_GO;
          end
        end
        S_BYTE_GO: st_q <= S_BYTE_WAIT;
        S_BYTE_WAIT: if (eng_done_i) begin
          if (idx_q == last_idx_i) begin
            done_o <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= S_BYTE_GO;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign cmd_valid_o = (st_q == S_RST_GO) || (st_q == S_BYTE_GO);
  assign cmd_kind_o  = (st_q == S_BYTE_GO) ? CMD_WRITE : CMD_RESET;

  assert_reset_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (cmd_valid_o && cmd_kind_o == CMD_RESET));
  assert_cmd_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  assert_wait_engine_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_BYTE_WAIT || st_q == S_RST_WAIT) && !eng_done_i) |=> !cmd_valid_o);
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> (done_o || $past(load_o)));
endmodule

// File: rtl/onew_sel_seq.sv
module onew_sel_seq
  import onew_sel_pkg::*;
#(
  parameter int SLV_W    = 8,
  parameter int ID_BYTES = 8,
  localparam int IDX_W = $clog2(ID_BYTES + 1),
  localparam int ID_W  = ID_BYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SLV_W-1:0] slave_count_i,
  input  logic [ID_W-1:0]  target_id_i,
  output logic             cmd_valid_o,
  output logic             cmd_kind_o,
  output logic [7:0]       cmd_byte_o,
  input  logic             eng_done_i,
  input  logic             eng_presence_i,
  output logic             done_o,
  output logic             err_o
);
  logic [ID_W-1:0]  id_q;
  logic             skip_q;
  logic             load, busy;
  logic [IDX_W-1:0] idx, last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      skip_q <= 1'b0;
    end else if (load) begin
      id_q   <= target_id_i;
      skip_q <= (slave_count_i == SLV_W'(1));
    end
  end

  onew_byte_sched #(.ID_BYTES(ID_BYTES)) u_sched (
    .id_i       (id_q),
    .skip_i     (skip_q),
    .idx_i      (idx),
    .byte_o     (cmd_byte_o),
    .last_idx_o (last_idx)
  );

  onew_sel_fsm #(.ID_BYTES(ID_BYTES)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .eng_done_i     (eng_done_i),
    .eng_presence_i (eng_presence_i),
    .last_idx_i     (last_idx),
    .load_o         (load),
    .busy_o         (busy),
    .idx_o          (idx),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_kind_o     (cmd_kind_o),
    .done_o         (done_o),
    .err_o          (err_o)
  );

  // write commands issued since the last accepted start, for the checks below
  logic [IDX_W:0] wr_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 wr_cnt_q <= '0;
    else if (load)                               wr_cnt_q <= '0;
    else if (cmd_valid_o && cmd_kind_o == CMD_WRITE) wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  assert_no_bytes_on_absent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (wr_cnt_q == '0));
  assert_skip_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && skip_q) |-> (wr_cnt_q == (IDX_W+1)'(1)));
  assert_match_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && !skip_q) |-> (wr_cnt_q == (IDX_W+1)'(ID_BYTES + 1)));
  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> ($stable(id_q) && $stable(skip_q)));
endmodule

// File: tb/onew_sel_seq_tb.sv
module onew_sel_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  slave_count_i = '0;
  logic [63:0] target_id_i = '0;
  logic        cmd_valid_o, cmd_kind_o, done_o, err_o;
  logic [7:0]  cmd_byte_o;
  logic        eng_done_i = 1'b0;
  logic        eng_presence_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  onew_sel_seq dut_i (
    .clk_i, .rst_ni, .start_i, .slave_count_i, .target_id_i,
    .cmd_valid_o, .cmd_kind_o, .cmd_byte_o,
    .eng_done_i, .eng_presence_i, .done_o, .err_o
  );

  int errors = 0;
  int checks = 0;
  logic [8:0] exp_q [$];
  int lat_cfg = 1;
  logic pres_cfg = 1'b1;
  int pend = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // engine model + scoreboard monitor
  always @(negedge clk_i) begin
    eng_done_i <= 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        eng_done_i     <= 1'b1;
        eng_presence_i <= pres_cfg;
      end
    end
    if (cmd_valid_o && rst_ni) begin
      logic [8:0] act, exp;
      act = {cmd_kind_o, cmd_kind_o ? cmd_byte_o : 8'h00};
      chk(pend == 0, "R5", "command while engine busy", 64'(pend), 64'd0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected command", 64'(act), 64'h1ff);
      end else begin
        exp = exp_q.pop_front();
        chk(act == exp, exp[8] ? "R4" : "R1", "command", 64'(act), 64'(exp));
      end
      pend = lat_cfg;
    end
  end

  task automatic run_sel(input logic [7:0] cnt, input logic [63:0] id,
                         input logic pres, input int lat, input bit disturb,
                         input string req);
    int t;
    exp_q.push_back({1'b0, 8'h00});
    if (pres) begin
      if (cnt == 8'd1) exp_q.push_back({1'b1, 8'hCC});
      else begin
        exp_q.push_back({1'b1, 8'h55});
        for (int k = 0; k < 8; k++) exp_q.push_back({1'b1, id[k*8 +: 8]});
      end
    end
    pres_cfg = pres;
    lat_cfg  = lat;
    @(negedge clk_i);
    slave_count_i = cnt;
    target_id_i   = id;
    start_i       = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(cmd_valid_o && !cmd_kind_o, "R1", "reset issued after start",
        64'({cmd_valid_o, cmd_kind_o}), 64'h2);
    chk(!err_o, "R7", "err cleared by start", 64'(err_o), 64'd0);
    if (disturb) begin
      repeat (6) @(negedge clk_i);
      target_id_i   = ~id;
      slave_count_i = (cnt == 8'd1) ? 8'd3 : 8'd1;
      start_i       = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 2000) begin
      @(negedge clk_i);
      t++;
    end
    chk(done_o, req, "done seen", 64'(done_o), 64'd1);
    chk(err_o == !pres, pres ? req : "R2", "err at done", 64'(err_o), 64'(!pres));
    chk(exp_q.size() == 0, req, "commands left", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    @(negedge clk_i);
    chk(!done_o, "R6", "done single cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cmd_valid_o && !done_o && !err_o, "R10", "reset state",
        64'({cmd_valid_o, done_o, err_o}), 64'd0);
    run_sel(8'd1, 64'h0123456789abcdef, 1'b1, 1, 1'b0, "R3");
    run_sel(8'd2, 64'h8877665544332211, 1'b1, 1, 1'b0, "R4");
    run_sel(8'd0, 64'hdeadbeef00c0ffee, 1'b1, 3, 1'b0, "R4");
    run_sel(8'd5, 64'h1122334455667700, 1'b0, 4, 1'b0, "R2");
    repeat (10) @(negedge clk_i);
    chk(err_o, "R7", "err held while idle", 64'(err_o), 64'd1);
    run_sel(8'd255, 64'hf0e1d2c3b4a59687, 1'b1, 5, 1'b1, "R9");
    run_sel(8'd1, 64'h55aa55aa55aa55aa, 1'b1, 6, 1'b1, "R8");
    run_sel(8'd7, 64'h0000000000000001, 1'b0, 1, 1'b0, "R2");
    run_sel(8'd7, 64'h0000000000000001, 1'b1, 2, 1'b0, "R4");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule